// File: doc/BRIEF.md
# BCD calendar with buffered update

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours (24-hour), day of week, day of month, month, two-digit year and a century byte. A one-cycle `tick_1hz` enable advances an internal working copy once per second. A separate user copy sits behind a byte-wide register bus, and software reads the time from that copy.

About LEAD_CYC cycles after each tick, the working copy is transferred into the user copy. For that whole window an update-in-progress flag is raised in the status register, so software knows a transfer is coming. The flag drops on the cycle the transfer completes, and `upd_done` pulses once at the same moment.

A hold control freezes the user copy. While it is set, software may rewrite any time byte without a transfer overwriting its work, and the working copy keeps counting. When the hold is released after at least one time write, the next tick loads the working copy from the user copy instead of advancing it. When it is released with no write, the next transfer shows the time that kept running underneath.

A small scratch RAM and both control registers can be used at any time, including during the update window.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, addresses 0 to 7 (seconds, minutes, hours, weekday, day of month, month, year, century) read 00, 00, 00, 01, 01, 01, 00 and CENT_INIT. Addresses 8 and 9 read 00.
- R2: Each tick advances the seconds in BCD. Seconds and minutes wrap 59 to 00 with a carry, and hours wrap 23 to 00 with a carry.
- R3: On a day carry the day of month wraps to 01 after the month's last day, using 30 days for months 04, 06, 09 and 11 and 31 days for the others. The weekday wraps from 07 to 01.
- R4: February has 29 days when the year is a multiple of four, with one exception: year 00 counts as a leap year only when the century byte is a multiple of four. So 2000 is a leap year and 2100 is not.
- R5: Year 99 wraps to 00 and increments the century byte.
- R6: Bit 7 of address 8 is the update-in-progress flag. It is 1 for exactly LEAD_CYC cycles starting the cycle after a tick. It reads 0 on the cycle the user copy takes the new time, and `upd_done` is 1 for that one cycle only.
- R7: Bit 7 of address 9 is the hold bit. While it is 1, the user copy is never refreshed, writes to addresses 0 to 7 land in the user copy, and ticks still advance the working copy.
- R8: While the hold bit is 0, writes to addresses 0 to 7 have no effect.
- R9: Clearing the hold bit after at least one time write makes the next tick copy the user bytes unchanged into the working copy, without an advance. Clearing it with no time write lets the next transfer show the working time that kept advancing.
- R10: RAM_DEPTH bytes starting at address RAM_BASE can be written and read back at any time, including while the update-in-progress flag is 1.
- R11: Writes to address 8 have no effect. Addresses that are not mapped read 00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle once-per-second advance enable |
| bus_wr | input | 1 | Write strobe for the addressed byte |
| bus_addr | input | ADDR_W | Register or RAM byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| upd_done | output | 1 | One-cycle pulse when an update window ends |

## Verification
The bench overrides the defaults with LEAD_CYC = 3, four RAM bytes at addresses 12 to 15 and a century start of 20. With these values the update window is short enough that a RAM write and its read-back both fall inside one window. They also leave addresses 10, 11 and 16 upward unmapped, so the ignore and read-zero rules can be checked at both ends of the RAM. Preloading times just before month, leap-day, year and century boundaries puts each rollover one tick away. This covers 2000 as a leap year, 2100 and 2023 as common years, and the carry into the century byte.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   typedef struct packed {
      logic [7:0] sec;
      logic [7:0] min;
      logic [7:0] hour;
      logic [7:0] wday;
      logic [7:0] mday;
      logic [7:0] mon;
      logic [7:0] year;
      logic [7:0] cent;
   } cal_t;

   localparam int unsigned FLAG_BIT = 7;

   function automatic logic [6:0] bcd_val(input logic [7:0] b);
      return {3'd0, b[7:4]} * 7'd10 + {3'd0, b[3:0]};
   endfunction

   function automatic logic [7:0] bcd_step(input logic [7:0] b);
      if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
      return {b[7:4], b[3:0] + 4'd1};
   endfunction

   function automatic logic leap_year(input logic [7:0] yy, input logic [7:0] cc);
      logic [6:0] y;
      logic [6:0] c;
      y = bcd_val(yy);
      c = bcd_val(cc);
      if (y[1:0] != 2'd0) return 1'b0;
      if (y != 7'd0)      return 1'b1;
      return (c[1:0] == 2'd0);
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] mm, input logic lp);
      case (mm)
         8'h02:                      return lp ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic logic [7:0] field_get(input cal_t c, input logic [2:0] idx);
      case (idx)
         3'd0:    return c.sec;
         3'd1:    return c.min;
         3'd2:    return c.hour;
         3'd3:    return c.wday;
         3'd4:    return c.mday;
         3'd5:    return c.mon;
         3'd6:    return c.year;
         default: return c.cent;
      endcase
   endfunction

   function automatic cal_t field_put(input cal_t c, input logic [2:0] idx,
                                      input logic [7:0] v);
      cal_t r;
      r = c;
      case (idx)
         3'd0:    r.sec  = v;
         3'd1:    r.min  = v;
         3'd2:    r.hour = v;
         3'd3:    r.wday = v;
         3'd4:    r.mday = v;
         3'd5:    r.mon  = v;
         3'd6:    r.year = v;
         default: r.cent = v;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
   import rtc_cal_pkg::*;
#(
   parameter logic [7:0] WDAY_LAST = 8'h07
) (
   input  cal_t cur,
   output cal_t nxt
);
   localparam int unsigned TOD_N = 3;
   localparam logic [7:0] TOD_MAX [TOD_N] = '{8'h59, 8'h59, 8'h23};

   logic [7:0]     tod_cur [TOD_N];
   logic [7:0]     tod_nxt [TOD_N];
   logic [TOD_N:0] carry;
   logic           lp;
   logic [7:0]     mlen;
   logic           d_wrap;
   logic           m_wrap;
   logic           y_wrap;

   assign tod_cur[0] = cur.sec;
   assign tod_cur[1] = cur.min;
   assign tod_cur[2] = cur.hour;
   assign carry[0]   = 1'b1;

   for (genvar i = 0; i < TOD_N; i++) begin : g_tod
      assign carry[i+1] = carry[i] && (tod_cur[i] >= TOD_MAX[i]);
      assign tod_nxt[i] = !carry[i]   ? tod_cur[i] :
                          carry[i+1]  ? 8'h00 : bcd_step(tod_cur[i]);
   end

   assign lp     = leap_year(cur.year, cur.cent);
   assign mlen   = month_len(cur.mon, lp);
   assign d_wrap = carry[TOD_N] && (cur.mday >= mlen);
   assign m_wrap = d_wrap && (cur.mon >= 8'h12);
   assign y_wrap = m_wrap && (cur.year >= 8'h99);

   always_comb begin
      nxt      = cur;
      nxt.sec  = tod_nxt[0];
      nxt.min  = tod_nxt[1];
      nxt.hour = tod_nxt[2];
      if (carry[TOD_N]) begin
         nxt.wday = (cur.wday >= WDAY_LAST) ? 8'h01 : cur.wday + 8'h01;
         nxt.mday = d_wrap ? 8'h01 : bcd_step(cur.mday);
      end
      if (d_wrap) nxt.mon  = m_wrap ? 8'h01 : bcd_step(cur.mon);
      if (m_wrap) nxt.year = y_wrap ? 8'h00 : bcd_step(cur.year);
      if (y_wrap) nxt.cent = (cur.cent >= 8'h99) ? 8'h00 : bcd_step(cur.cent);
   end
endmodule

// File: rtl/rtc_cal_seq.sv
module rtc_cal_seq #(
   parameter int unsigned LEAD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hold,
   output logic uip,
   output logic xfer,
   output logic done
);
   localparam int unsigned CW = $clog2(LEAD_CYC + 1);

   if (LEAD_CYC < 1) begin : g_bad_lead
      $error("rtc_cal_seq: LEAD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            cnt_q <= CW'(LEAD_CYC);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) done <= 1'b1;
         end
      end
   end

   assign uip  = (cnt_q != '0);
   assign xfer = !tick && (cnt_q == CW'(1)) && !hold;

   // R6
   uip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uip) |-> $past(tick));
   // R6
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!uip && $past(uip)));
   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/rtc_cal_ram.sv
module rtc_cal_ram #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned IW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] idx,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   if (DEPTH > (1 << IW)) begin : g_bad_iw
      $error("rtc_cal_ram: IW too narrow for DEPTH");
   end

   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= 8'h00;
      end else if (we) begin
         mem_q[idx] <= wdata;
      end
   end

   assign rdata = mem_q[idx];

   // R10
   ram_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata == $past(wdata) || idx != $past(idx)));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_cal_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned LEAD_CYC  = 4,
   parameter int unsigned RAM_BASE  = 16,
   parameter int unsigned RAM_DEPTH = 8,
   parameter logic [7:0]  CENT_INIT = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              upd_done
);
   localparam int unsigned RAM_IW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(9);
   localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(RAM_BASE);
   localparam logic [ADDR_W-1:0] RAM_HI = ADDR_W'(RAM_BASE + RAM_DEPTH - 1);
   localparam cal_t CAL_INIT = '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                                 mday: 8'h01, mon: 8'h01, year: 8'h00, cent: CENT_INIT};

   if (ADDR_W < 4) begin : g_bad_aw
      $error("rtc_calendar: ADDR_W must be at least 4");
   end
   if (RAM_DEPTH == 1) begin : g_bad_depth
      $error("rtc_calendar: RAM_DEPTH must be 0 or at least 2");
   end
   if (RAM_DEPTH != 0 && (RAM_BASE < 10 || RAM_BASE + RAM_DEPTH > (1 << ADDR_W))) begin : g_bad_base
      $error("rtc_calendar: RAM window overlaps registers or exceeds address space");
   end

   cal_t t_q, u_q, t_nxt;
   logic set_q, dirty_q, pend_q;
   logic uip, xfer, load;
   logic is_time, is_ram, time_wr, ctrl_wr;
   logic [7:0] ram_rdata;

   assign is_time = (bus_addr[ADDR_W-1:3] == '0);
   assign is_ram  = (RAM_DEPTH != 0) && (bus_addr >= RAM_LO) && (bus_addr <= RAM_HI);
   assign time_wr = bus_wr && is_time && set_q;
   assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
   assign load    = tick_1hz && pend_q && !set_q;

   rtc_cal_advance u_adv (
      .cur (t_q),
      .nxt (t_nxt)
   );

   rtc_cal_seq #(.LEAD_CYC(LEAD_CYC)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_1hz),
      .hold  (set_q),
      .uip   (uip),
      .xfer  (xfer),
      .done  (upd_done)
   );

   if (RAM_DEPTH != 0) begin : g_ram
      rtc_cal_ram #(.DEPTH(RAM_DEPTH), .IW(RAM_IW)) u_ram (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (bus_wr && is_ram),
         .idx   (RAM_IW'(bus_addr - RAM_LO)),
         .wdata (bus_wdata),
         .rdata (ram_rdata)
      );
   end else begin : g_no_ram
      assign ram_rdata = 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_q     <= CAL_INIT;
         u_q     <= CAL_INIT;
         set_q   <= 1'b0;
         dirty_q <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         if (tick_1hz) t_q <= load ? u_q : t_nxt;
         if (load)     pend_q <= 1'b0;
         if (xfer)     u_q <= t_q;
         if (time_wr) begin
            u_q     <= field_put(u_q, bus_addr[2:0], bus_wdata);
            dirty_q <= 1'b1;
         end
         if (ctrl_wr) begin
            set_q <= bus_wdata[FLAG_BIT];
            if (set_q && !bus_wdata[FLAG_BIT]) begin
               pend_q  <= dirty_q;
               dirty_q <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      bus_rdata = 8'h00;
      if (is_time)                 bus_rdata = field_get(u_q, bus_addr[2:0]);
      else if (bus_addr == A_STAT) bus_rdata = {uip, 7'd0};
      else if (bus_addr == A_CTRL) bus_rdata = {set_q, 7'd0};
      else if (is_ram)             bus_rdata = ram_rdata;
   end

   // R2
   tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !load) |=> (t_q != $past(t_q)));
   // R7
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_q && !time_wr) |=> (u_q == $past(u_q)));
   // R8
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_q && !xfer) |=> (u_q == $past(u_q)));
   // R9
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (t_q == $past(u_q)));
   // R5
   cent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !load && t_q.year == 8'h99 && t_q.mon == 8'h12 && t_q.mday == 8'h31
       && t_q.hour == 8'h23 && t_q.min == 8'h59 && t_q.sec == 8'h59)
      |=> (t_q.year == 8'h00 && t_q.cent != $past(t_q.cent)));
endmodule

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
   localparam int LEAD = 3, RDEP = 4, RBASE = 12, AW = 5;

   logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = 8'h00;
   logic [7:0]    rdata;
   logic          done;
   int checks = 0, fails = 0;

   rtc_calendar #(.ADDR_W(AW), .LEAD_CYC(LEAD), .RAM_BASE(RBASE), .RAM_DEPTH(RDEP),
                  .CENT_INIT(8'h20)) uut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .upd_done(done));

   always #2 clk = ~clk;

   // behavioural reference: working time as integers, user copy as bytes
   int         mt [8];
   logic [7:0] mu [8];
   logic [7:0] mram [RDEP];
   int         mcnt;
   bit         mset, mdirty, mpend, mdone;

   function automatic logic [7:0] to_bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction
   function automatic int from_bcd(logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction
   function automatic int mdays(int m, int y, int c);
      bit lp;
      lp = (y % 4 == 0) && (y != 0 || c % 4 == 0);
      case (m)
         2: return lp ? 29 : 28;
         4, 6, 9, 11: return 30;
         default: return 31;
      endcase
   endfunction

   task automatic m_advance();
      mt[0]++;
      if (mt[0] == 60) begin
         mt[0] = 0; mt[1]++;
         if (mt[1] == 60) begin
            mt[1] = 0; mt[2]++;
            if (mt[2] == 24) begin
               mt[2] = 0; mt[3] = (mt[3] >= 7) ? 1 : mt[3] + 1; mt[4]++;
               if (mt[4] > mdays(mt[5], mt[6], mt[7])) begin
                  mt[4] = 1; mt[5]++;
                  if (mt[5] == 13) begin
                     mt[5] = 1; mt[6]++;
                     if (mt[6] == 100) begin mt[6] = 0; mt[7] = (mt[7] + 1) % 100; end
                  end
               end
            end
         end
      end
   endtask

   function automatic logic [7:0] m_read(int a);
      if (a < 8) return mu[a];
      if (a == 8) return {(mcnt != 0), 7'd0};
      if (a == 9) return {mset, 7'd0};
      if (a >= RBASE && a < RBASE + RDEP) return mram[a - RBASE];
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      bit oset, ndone;
      int ai;
      ai = int'(addr);
      if (!rst_n) begin
         mt = '{0, 0, 0, 1, 1, 1, 0, 20};
         foreach (mu[i]) mu[i] = to_bcd(mt[i]);
         foreach (mram[i]) mram[i] = 8'h00;
         mcnt = 0; mset = 0; mdirty = 0; mpend = 0; mdone = 0;
      end else begin
         oset = mset; ndone = 0;
         if (tick) begin
            if (mpend && !oset) begin
               foreach (mt[i]) mt[i] = from_bcd(mu[i]);
               mpend = 0;
            end else m_advance();
            mcnt = LEAD;
         end else if (mcnt != 0) begin
            if (mcnt == 1) begin
               ndone = 1;
               if (!oset) foreach (mu[i]) mu[i] = to_bcd(mt[i]);
            end
            mcnt--;
         end
         mdone = ndone;
         if (wr) begin
            if (ai < 8 && oset) begin mu[ai] = wdata; mdirty = 1; end
            if (ai == 9) begin
               if (oset && !wdata[7]) begin mpend = mdirty; mdirty = 0; end
               mset = wdata[7];
            end
            if (ai >= RBASE && ai < RBASE + RDEP) mram[ai - RBASE] = wdata;
         end
      end
   end

   // compared on every clock, away from the active edge
   always @(negedge clk) begin
      logic [7:0] e;
      int ai;
      if (rst_n) begin
         ai = int'(addr);
         e = m_read(ai);
         checks++;
         if (rdata !== e) begin
            fails++;
            $display("FAIL %s: addr %0d rdata %h expected %h",
                     (ai < 8) ? "R7" : (ai == 8) ? "R6" : "R10", ai, rdata, e);
         end
         checks++;
         if (done !== mdone) begin
            fails++;
            $display("FAIL R6: upd_done %b expected %b", done, mdone);
         end
      end
   end

   task automatic step(input bit w, input int a, input logic [7:0] d, input bit t);
      @(posedge clk); #1;
      wr = w; addr = AW'(a); wdata = d; tick = t;
   endtask

   task automatic expect_reg(input int a, input logic [7:0] exp, input string tag);
      step(1'b0, a, 8'h00, 1'b0);
      @(negedge clk);
      checks++;
      if (rdata !== exp) begin
         fails++;
         $display("FAIL %s: reg %0d read %h, expected %h", tag, a, rdata, exp);
      end
   endtask

   task automatic do_tick();
      step(1'b0, int'(addr), 8'h00, 1'b1);
      repeat (LEAD + 2) step(1'b0, int'(addr), 8'h00, 1'b0);
   endtask

   task automatic load_time(input logic [7:0] s, mi, h, wd, d, mo, y, c);
      logic [7:0] v [8];
      v = '{s, mi, h, wd, d, mo, y, c};
      step(1'b1, 9, 8'h80, 1'b0);
      for (int i = 0; i < 8; i++) step(1'b1, i, v[i], 1'b0);
      step(1'b1, 9, 8'h00, 1'b0);
      do_tick();
   endtask

   initial begin
      #800000;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      expect_reg(0, 8'h00, "R1"); expect_reg(1, 8'h00, "R1"); expect_reg(2, 8'h00, "R1");
      expect_reg(3, 8'h01, "R1"); expect_reg(4, 8'h01, "R1"); expect_reg(5, 8'h01, "R1");
      expect_reg(6, 8'h00, "R1"); expect_reg(7, 8'h20, "R1");
      expect_reg(8, 8'h00, "R1"); expect_reg(9, 8'h00, "R1");
      // R2 first tick
      do_tick();
      expect_reg(0, 8'h01, "R2");
      // R6 update window with R10 RAM access inside it
      step(1'b0, 8, 8'h00, 1'b1);
      step(1'b1, RBASE, 8'h5A, 1'b0);
      expect_reg(RBASE, 8'h5A, "R10");
      expect_reg(8, 8'h80, "R6");
      expect_reg(8, 8'h00, "R6");
      expect_reg(0, 8'h02, "R6");
      // R4 leap day in 2000, R2 full carry, R3 weekday
      load_time(8'h58, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00, 8'h20);
      expect_reg(0, 8'h58, "R9");
      do_tick();
      expect_reg(0, 8'h59, "R2");
      do_tick();
      expect_reg(4, 8'h29, "R4"); expect_reg(2, 8'h00, "R2");
      expect_reg(1, 8'h00, "R2"); expect_reg(3, 8'h03, "R3");
      // R4 2100 is not a leap year
      load_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h28, 8'h02, 8'h00, 8'h21);
      do_tick();
      expect_reg(4, 8'h01, "R4"); expect_reg(5, 8'h03, "R4");
      // R5 year and century carry, R3 weekday wrap
      load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20);
      do_tick();
      expect_reg(6, 8'h00, "R5"); expect_reg(7, 8'h21, "R5");
      expect_reg(5, 8'h01, "R5"); expect_reg(3, 8'h01, "R3");
      // R3 thirty-day month
      load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24, 8'h20);
      do_tick();
      expect_reg(4, 8'h01, "R3"); expect_reg(5, 8'h05, "R3");
      // R4 common year 2023
      load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h20);
      do_tick();
      expect_reg(5, 8'h03, "R4"); expect_reg(4, 8'h01, "R4");
      // R7 freeze without writes; working time keeps counting
      step(1'b1, 9, 8'h80, 1'b0);
      do_tick(); do_tick(); do_tick();
      expect_reg(0, 8'h00, "R7");
      expect_reg(9, 8'h80, "R7");
      step(1'b1, 9, 8'h00, 1'b0);
      do_tick();
      expect_reg(0, 8'h04, "R9");
      // R8 write ignored while hold is clear
      step(1'b1, 0, 8'h33, 1'b0);
      expect_reg(0, 8'h04, "R8");
      // R9 write during hold, load at next tick without advance
      step(1'b1, 9, 8'h80, 1'b0);
      step(1'b1, 1, 8'h45, 1'b0);
      step(1'b1, 9, 8'h00, 1'b0);
      expect_reg(1, 8'h45, "R7");
      do_tick();
      expect_reg(0, 8'h04, "R9"); expect_reg(1, 8'h45, "R9");
      do_tick();
      expect_reg(0, 8'h05, "R9");
      // R11 status write, unmapped addresses; R10 RAM bounds
      step(1'b1, 8, 8'h80, 1'b0);
      expect_reg(8, 8'h00, "R11");
      step(1'b1, 16, 8'hA5, 1'b0);
      expect_reg(16, 8'h00, "R11");
      step(1'b1, 10, 8'h77, 1'b0);
      expect_reg(10, 8'h00, "R11");
      step(1'b1, RBASE + 3, 8'hC3, 1'b0);
      expect_reg(RBASE + 3, 8'hC3, "R10");
      expect_reg(RBASE, 8'h5A, "R10");
      repeat (4) step(1'b0, 0, 8'h00, 1'b0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule